// File: doc/BRIEF.md
# Interrupt status and IRQ generator

This block gathers completion events from a motion co-processor and turns them into one active-low interrupt pin and a status word. Two event sources feed it: the A/D conversion sequencer and the vector transformation engine. Each source has its own enable bit. An event that arrives while its enable bit is clear is dropped. An enabled event sets that source's flag and a summary "device interrupted" flag, and it also drives the interrupt pin.

A pin-format bit picks how the pin behaves. In one setting, each event gives a low pulse lasting exactly one clock. In the other, the pin goes low and stays low until software reads the status word. A read strobe clears the interrupt flags. The rotation-valid bit in the same word is not affected by a read. If an event arrives in the same cycle as a read, the event wins, so no completion is ever lost.

The status word is always presented on `stat_o`. The strobe `stat_rd_i` marks the cycle in which the bus reads it, and the clearing takes effect at the following clock edge.

Top module: `irq_status_ctrl`

## Requirements
- R1: While reset is active, and after it is released with no events applied, `stat_o` is all zeros and `irq_n_o` is 1.
- R2: An `adc_done_i` pulse with `adc_irq_en_i`=1 sets status bit 0 at the next clock edge. With `adc_irq_en_i`=0, the pulse leaves bit 0, bit 11 and the pin unchanged.
- R3: An `xform_done_i` pulse with `xform_irq_en_i`=1 sets status bit 1 at the next clock edge. With `xform_irq_en_i`=0, the pulse leaves bit 1, bit 11 and the pin unchanged.
- R4: Status bit 11 is set at the next edge whenever either enabled source fires. It is never 0 while bit 0 or bit 1 is 1.
- R5: `stat_rd_i`=1 clears bits 0, 1 and 11 at the next edge. A flag whose enabled event arrives in the same cycle as the read is set instead.
- R6: Once a cycle with `xform_start_i`=1 has occurred, status bit 4 equals the value `rot_valid_i` had in the previous cycle. A read does not clear bit 4.
- R7: With `irq_mode_i`=0 (pulse format), `irq_n_o` is 0 in exactly the cycle after each cycle that has an enabled event, and 1 otherwise.
- R8: With `irq_mode_i`=1 (level format), an enabled event drives `irq_n_o` to 0 at the next edge. The pin stays 0 until the edge after a read, where it returns to 1, unless an enabled event coincides with that read.
- R9: Status bits other than 0, 1, 4 and 11 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_done_i | input | 1 | A/D conversion complete pulse |
| adc_irq_en_i | input | 1 | Enable for A/D completion interrupts |
| xform_done_i | input | 1 | Vector transformation complete pulse |
| xform_irq_en_i | input | 1 | Enable for transformation completion interrupts |
| xform_start_i | input | 1 | A vector transformation is starting |
| rot_valid_i | input | 1 | Rotation results currently valid |
| irq_mode_i | input | 1 | Pin format: 0 one-clock pulse, 1 held level |
| stat_rd_i | input | 1 | Status word is read in this cycle |
| stat_o | output | 16 | Status word (bits 0, 1, 4, 11 used) |
| irq_n_o | output | 1 | Active-low interrupt pin |

## Verification
The hardest states to reach are the collisions. One is a read that lands in the same cycle as a fresh enabled event. Another is a change of pin format while the level output is being held low. A third is a disabled event that arrives while flags set earlier are still pending. To reach these, the bench steps through every combination of the eight control inputs, one combination per cycle. It does this in three scrambled orders, using odd multipliers modulo 256, so each combination meets many different prior flag and pin states. A directed sequence then holds the level output low across idle cycles and releases it with a read.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int STAT_W  = 16;
  localparam int NSRC    = 2;
  localparam int ADC_BIT = 0;
  localparam int XF_BIT  = 1;
  localparam int ROT_BIT = 4;
  localparam int ANY_BIT = 11;

  typedef enum logic {
    PIN_PULSE = 1'b0,
    PIN_LEVEL = 1'b1
  } pin_mode_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            rd_i,
  output logic [NSRC-1:0] flag_o,
  output logic            any_o,
  output logic            fire_o
);
  logic [NSRC-1:0] fire_vec;
  logic            any_q, any_d;
  logic            upd_en;

  always_comb begin
    fire_vec = ev_i & en_i;
    fire_o   = |fire_vec;
    upd_en   = fire_o | rd_i;
    any_d    = fire_o | (any_q & ~rd_i);
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic flag_q, flag_d;

    always_comb begin
      flag_d = fire_vec[g] | (flag_q & ~rd_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (upd_en) flag_q <= flag_d;
    end

    assign flag_o[g] = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      any_q <= 1'b0;
    else if (upd_en) any_q <= any_d;
  end

  assign any_o = any_q;
endmodule

// File: rtl/irq_pin_gen.sv
module irq_pin_gen
  import irq_stat_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fire_i,
  input  pin_mode_e mode_i,
  input  logic      rd_i,
  output logic      irq_n_o
);
  logic low_q, low_d;

  always_comb begin
    if (mode_i == PIN_LEVEL) low_d = fire_i | (low_q & ~rd_i);
    else                     low_d = fire_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= 1'b0;
    else        low_q <= low_d;
  end

  assign irq_n_o = ~low_q;
endmodule

// File: rtl/irq_rot_track.sv
module irq_rot_track (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic valid_i,
  output logic rot_o
);
  logic seen_q, seen_d;
  logic rot_q;
  logic rot_en;

  always_comb begin
    seen_d = seen_q | start_i;
    rot_en = seen_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      rot_q  <= 1'b0;
    end else begin
      seen_q <= seen_d;
      if (rot_en) rot_q <= valid_i;
    end
  end

  assign rot_o = rot_q;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adc_done_i,
  input  logic              adc_irq_en_i,
  input  logic              xform_done_i,
  input  logic              xform_irq_en_i,
  input  logic              xform_start_i,
  input  logic              rot_valid_i,
  input  logic              irq_mode_i,
  input  logic              stat_rd_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_n_o
);
  logic            rst_core_n;
  logic [NSRC-1:0] ev_vec, en_vec, flag_vec;
  logic            any_flag, fire, rot_bit;
  pin_mode_e       pin_mode;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n)
  );

  always_comb begin
    ev_vec          = '0;
    en_vec          = '0;
    ev_vec[ADC_BIT] = adc_done_i;
    en_vec[ADC_BIT] = adc_irq_en_i;
    ev_vec[XF_BIT]  = xform_done_i;
    en_vec[XF_BIT]  = xform_irq_en_i;
    pin_mode        = irq_mode_i ? PIN_LEVEL : PIN_PULSE;
  end

  irq_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_core_n), .ev_i(ev_vec), .en_i(en_vec),
    .rd_i(stat_rd_i), .flag_o(flag_vec), .any_o(any_flag), .fire_o(fire)
  );

  irq_pin_gen u_pin (
    .clk(clk), .rst_n(rst_core_n), .fire_i(fire), .mode_i(pin_mode),
    .rd_i(stat_rd_i), .irq_n_o(irq_n_o)
  );

  irq_rot_track u_rot (
    .clk(clk), .rst_n(rst_core_n), .start_i(xform_start_i),
    .valid_i(rot_valid_i), .rot_o(rot_bit)
  );

  always_comb begin
    stat_o          = '0;
    stat_o[ADC_BIT] = flag_vec[ADC_BIT];
    stat_o[XF_BIT]  = flag_vec[XF_BIT];
    stat_o[ROT_BIT] = rot_bit;
    stat_o[ANY_BIT] = any_flag;
  end
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        adc_done_i,
  input logic        adc_irq_en_i,
  input logic        xform_done_i,
  input logic        xform_irq_en_i,
  input logic        xform_start_i,
  input logic        rot_valid_i,
  input logic        irq_mode_i,
  input logic        stat_rd_i,
  input logic [15:0] stat_o,
  input logic        irq_n_o
);
  logic adc_fire, xf_fire, any_fire, started_q;

  assign adc_fire = adc_done_i & adc_irq_en_i;
  assign xf_fire  = xform_done_i & xform_irq_en_i;
  assign any_fire = adc_fire | xf_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             started_q <= 1'b0;
    else if (xform_start_i) started_q <= 1'b1;
  end

  assert_adc_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_fire |=> stat_o[0]);
  assert_xf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xf_fire |=> stat_o[1]);
  assert_any_cover_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o[0] || stat_o[1]) |-> stat_o[11]);
  assert_rd_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_i && !any_fire) |=> (stat_o[0] == 1'b0 && stat_o[1] == 1'b0 && stat_o[11] == 1'b0));
  assert_rot_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q || xform_start_i) |=> (stat_o[4] == $past(rot_valid_i)));
  assert_pulse_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_mode_i && !any_fire) |=> irq_n_o);
  assert_level_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode_i && !irq_n_o && !stat_rd_i) |=> !irq_n_o);
  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o & 16'hF7EC) == 16'h0000);
endmodule

bind irq_status_ctrl irq_status_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_core_n),
  .adc_done_i(adc_done_i), .adc_irq_en_i(adc_irq_en_i),
  .xform_done_i(xform_done_i), .xform_irq_en_i(xform_irq_en_i),
  .xform_start_i(xform_start_i), .rot_valid_i(rot_valid_i),
  .irq_mode_i(irq_mode_i), .stat_rd_i(stat_rd_i),
  .stat_o(stat_o), .irq_n_o(irq_n_o)
);

// File: tb/irq_status_ctrl_tb.sv
`timescale 1ns/1ps
module irq_status_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adc_done, adc_en, xf_done, xf_en, xf_start, rot_v, mode, rd;
  logic [15:0] stat;
  logic        irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic m_f0 = 1'b0, m_f1 = 1'b0, m_any = 1'b0, m_low = 1'b0;
  logic m_rot = 1'b0, m_started = 1'b0;

  always #2.5 clk = ~clk;

  irq_status_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .adc_done_i(adc_done), .adc_irq_en_i(adc_en),
    .xform_done_i(xf_done), .xform_irq_en_i(xf_en),
    .xform_start_i(xf_start), .rot_valid_i(rot_v),
    .irq_mode_i(mode), .stat_rd_i(rd),
    .stat_o(stat), .irq_n_o(irq_n)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // v: bit0 adc_done, 1 xf_done, 2 adc_en, 3 xf_en, 4 mode, 5 rd, 6 rot_valid, 7 xf_start
  task automatic step(input logic [7:0] v);
    logic fa, fx, fire;
    @(negedge clk);
    adc_done = v[0]; xf_done = v[1]; adc_en = v[2]; xf_en = v[3];
    mode = v[4]; rd = v[5]; rot_v = v[6]; xf_start = v[7];
    @(posedge clk);
    #1;
    fa    = v[0] & v[2];
    fx    = v[1] & v[3];
    fire  = fa | fx;
    m_f0  = fa | (m_f0 & ~v[5]);
    m_f1  = fx | (m_f1 & ~v[5]);
    m_any = fire | (m_any & ~v[5]);
    m_low = fire | (v[4] & m_low & ~v[5]);
    if (m_started || v[7]) begin
      m_started = 1'b1;
      m_rot = v[6];
    end
    check("R2,R5 bit0", {15'd0, stat[0]}, {15'd0, m_f0});
    check("R3,R5 bit1", {15'd0, stat[1]}, {15'd0, m_f1});
    check("R4,R5 bit11", {15'd0, stat[11]}, {15'd0, m_any});
    if (m_started) check("R6 bit4", {15'd0, stat[4]}, {15'd0, m_rot});
    check("R9 unused", stat & 16'hF7EC, 16'h0000);
    if (v[4]) check("R8 level pin", {15'd0, irq_n}, {15'd0, ~m_low});
    else      check("R7 pulse pin", {15'd0, irq_n}, {15'd0, ~m_low});
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    adc_done = 0; adc_en = 0; xf_done = 0; xf_en = 0;
    xf_start = 0; rot_v = 0; mode = 0; rd = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset status", stat, 16'h0000);
    check("R1 reset pin", {15'd0, irq_n}, 16'h0001);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 post-reset status", stat, 16'h0000);
    check("R1 post-reset pin", {15'd0, irq_n}, 16'h0001);

    // Scrambled exhaustive sweeps over all input combinations
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 256; i++) begin
        int mul;
        mul = (p == 0) ? 1 : ((p == 1) ? 37 : 101);
        step(8'((i * mul + p * 17) & 255));
      end
    end

    // Directed: level held across idle cycles, released by read (R8)
    step(8'h20);                 // clear everything, pulse mode
    step(8'h15);                 // level mode, enabled ADC event
    for (int k = 0; k < 5; k++) step(8'h10);
    check("R8 held before read", {15'd0, irq_n}, 16'h0000);
    step(8'h30);                 // read in level mode
    check("R8 released after read", {15'd0, irq_n}, 16'h0001);
    check("R5 flags cleared", stat & 16'h0803, 16'h0000);
    // Disabled events do nothing (R2, R3)
    step(8'h03);
    check("R2,R3 disabled events", stat & 16'h0803, 16'h0000);
    // Read colliding with an enabled transform event (R5)
    step(8'h2A);
    check("R5 event beats read", stat & 16'h0803, 16'h0802);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule